// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the command sequencer a boot program uses to reprogram on-chip flash from software. The CPU first writes a five-bit command into a control register. That write opens a short enable window. If a store strobe arrives inside the window, the block acts on the strobe's 16-bit data word and its word address. The address is a 16-bit pointer extended by an 8-bit page-select byte.

Depending on the command, the strobe does one of five things:
- writes the data word into a 128-word temporary page buffer;
- starts a page erase;
- starts a page write;
- raises a lock-bit set pulse;
- raises a pulse that re-enables read-while-write access.

Erase and write are handed to the flash array through a request/acknowledge handshake. While one runs, the block holds a busy flag. If the target page lies at or above a configurable section boundary, it also halts the CPU. A read port lets the flash array fetch buffer words during a page write.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, ctlBits, busy, cpuHalt, flashReq, lockStb and rwwStb are 0, and every page-buffer word reads 16'hFFFF.
- R2: ctlBits maps as follows: bit0 enable, bit1 erase, bit2 page write, bit3 lock set, bit4 read-while-write re-enable. Only the values 5'b00001 (fill), 5'b00011 (erase), 5'b00101 (page write), 5'b01001 (lock) and 5'b10001 (re-enable) are accepted. Writing any other value leaves ctlBits and the window unchanged.
- R3: A valid control write at clock edge T arms the window. A strobe at any of edges T+1 to T+4 is accepted. If no strobe arrives, ctlBits returns to 0 at edge T+4.
- R4: An accepted fill strobe stores storeData at buffer word zPtr[7:1], ignores zPtr[0], and clears ctlBits.
- R5: An accepted erase or page-write strobe has these effects from the next cycle:
  - busy is set;
  - flashReq is high for exactly one cycle;
  - flashOp is 0 for erase and 1 for write;
  - flashPage is {pageSel, zPtr[15:8]}.
  ctlBits keeps its value while busy, and clears with busy on the cycle after flashAck.
- R6: flashPage is latched when the operation starts. Later changes to zPtr or pageSel do not alter it.
- R7: cpuHalt is high throughout an erase or page write whose page is at or above NRWW_START (default 16'h00F0), and low otherwise.
- R8: A completed page write resets every buffer word to 16'hFFFF. A completed erase leaves the buffer unchanged.
- R9: An accepted lock strobe gives a one-cycle lockStb with lockBits = storeData[7:0], whatever the address. An accepted re-enable strobe gives a one-cycle rwwStb. Both clear ctlBits and issue no flash request.
- R10: The following are ignored:
  - a strobe while busy or outside an armed window;
  - a control write while busy;
  - flashAck while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 5 | Command value written |
| ctlBits | output | 5 | Current control register value |
| storeStb | input | 1 | Store strobe from CPU |
| storeData | input | 16 | Data word of the strobe |
| zPtr | input | 16 | Word/page pointer |
| pageSel | input | 8 | Extended page-select byte |
| busy | output | 1 | Erase or page write in progress |
| cpuHalt | output | 1 | CPU halt for protected-section target |
| flashReq | output | 1 | One-cycle request to flash array |
| flashOp | output | 1 | 0 erase, 1 page write |
| flashPage | output | 16 | Latched target page |
| flashAck | input | 1 | Flash array completion |
| lockStb | output | 1 | One-cycle lock-bit set pulse |
| lockBits | output | 8 | Lock value |
| rwwStb | output | 1 | One-cycle read-while-write re-enable pulse |
| bufRdAddr | input | 7 | Page-buffer read word index |
| bufRdData | output | 16 | Page-buffer read data |

## Verification
The hardest case to reach is a strobe during an operation that is already running, because the flash latency leaves only a short gap to hit. The bench stretches that gap by giving the flash model a long latency. Inside it, the bench moves the pointer, fires a store strobe and attempts a control write, then checks that the latched page, the buffer word and the command value are all unchanged. Window edges are reached by randomising the gap between the arming write and the strobe over zero to five idle cycles. This covers acceptance at the last edge of the window and rejection just after it.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

  typedef enum logic [4:0] {
    CMD_FILL  = 5'b00001,
    CMD_ERASE = 5'b00011,
    CMD_WRITE = 5'b00101,
    CMD_LOCK  = 5'b01001,
    CMD_RWW   = 5'b10001
  } fspCmd_e;

  typedef struct packed {
    logic fill;
    logic latch;
    logic clearBuf;
  } dpStb_t;

  function automatic logic isValidCmd(input logic [4:0] v);
    return (v == CMD_FILL) || (v == CMD_ERASE) || (v == CMD_WRITE) ||
           (v == CMD_LOCK) || (v == CMD_RWW);
  endfunction

endpackage

// File: rtl/fsp_ctrl.sv
module fsp_ctrl
  import fsp_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctlWrEn,
  input  logic [4:0]   ctlWrData,
  input  logic         storeStb,
  input  logic [7:0]   storeLowByte,
  input  logic         flashAck,
  input  logic         nrwwHit,
  output logic [4:0]   ctlBits,
  output logic         busy,
  output logic         cpuHalt,
  output logic         flashReq,
  output logic         flashOp,
  output logic         lockStb,
  output logic [7:0]   lockBits,
  output logic         rwwStb,
  output dpStb_t       stb
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(WINDOW - 1);

  logic [4:0]       ctlQ;
  logic [CNT_W-1:0] winCnt;
  logic             busyQ;
  logic             opWriteQ;
  logic             wrValid;
  logic             armed;
  logic             accept;

  assign wrValid = ctlWrEn && !busyQ && isValidCmd(ctlWrData);
  assign armed   = ctlQ[0] && !busyQ;
  assign accept  = storeStb && armed && !wrValid;

  always_comb begin
    stb.fill     = accept && (ctlQ == CMD_FILL);
    stb.latch    = accept && ((ctlQ == CMD_ERASE) || (ctlQ == CMD_WRITE));
    stb.clearBuf = busyQ && flashAck && opWriteQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ     <= '0;
      winCnt   <= '0;
      busyQ    <= 1'b0;
      opWriteQ <= 1'b0;
      flashReq <= 1'b0;
      lockStb  <= 1'b0;
      lockBits <= '0;
      rwwStb   <= 1'b0;
    end else begin
      flashReq <= 1'b0;
      lockStb  <= 1'b0;
      rwwStb   <= 1'b0;
      if (busyQ) begin
        if (flashAck) begin
          busyQ <= 1'b0;
          ctlQ  <= '0;
        end
      end else if (wrValid) begin
        ctlQ   <= ctlWrData;
        winCnt <= WIN_LOAD;
      end else if (accept) begin
        unique case (ctlQ)
          CMD_ERASE, CMD_WRITE: begin
            busyQ    <= 1'b1;
            flashReq <= 1'b1;
            opWriteQ <= (ctlQ == CMD_WRITE);
          end
          CMD_LOCK: begin
            lockStb  <= 1'b1;
            lockBits <= storeLowByte;
            ctlQ     <= '0;
          end
          CMD_RWW: begin
            rwwStb <= 1'b1;
            ctlQ   <= '0;
          end
          default: ctlQ <= '0;
        endcase
      end else if (ctlQ[0]) begin
        if (winCnt == '0) ctlQ <= '0;
        else winCnt <= winCnt - 1'b1;
      end
    end
  end

  assign ctlBits = ctlQ;
  assign busy    = busyQ;
  assign flashOp = opWriteQ;
  assign cpuHalt = busyQ && nrwwHit;

  // R5
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |-> busy);
  // R5
  single_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashReq |=> !flashReq);
  // R5
  enable_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ctlBits[0]);
  // R7
  halt_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> busy);
  // R2
  legal_ctl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlBits != 5'b0) |-> isValidCmd(ctlBits));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !flashAck) |=> busy);

endmodule

// File: rtl/fsp_datapath.sv
module fsp_datapath
  import fsp_pkg::*;
#(
  parameter int          WORD_W     = 7,
  parameter int          DATA_W     = 16,
  parameter int          Z_W        = 16,
  parameter int          SEL_W      = 8,
  parameter int unsigned NRWW_START = 240
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStb_t                        stb,
  input  logic [DATA_W-1:0]             storeData,
  input  logic [Z_W-1:0]                zPtr,
  input  logic [SEL_W-1:0]              pageSel,
  input  logic [WORD_W-1:0]             bufRdAddr,
  output logic [SEL_W+Z_W-WORD_W-2:0]   flashPage,
  output logic                          nrwwHit,
  output logic [DATA_W-1:0]             bufRdData
);

  localparam int PAGE_W = SEL_W + Z_W - WORD_W - 1;
  localparam int DEPTH  = 1 << WORD_W;
  localparam logic [PAGE_W-1:0] BOUNDARY = PAGE_W'(NRWW_START);

  logic [DATA_W-1:0] bufMem [DEPTH];
  logic [PAGE_W-1:0] pageQ;
  logic [WORD_W-1:0] wordIdx;
  logic              unusedZ0;

  assign wordIdx  = zPtr[WORD_W:1];
  assign unusedZ0 = zPtr[0];

  always_ff @(posedge clk) begin
    if (!rstN || stb.clearBuf) begin
      for (int i = 0; i < DEPTH; i++) bufMem[i] <= '1;
    end else if (stb.fill) begin
      bufMem[wordIdx] <= storeData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pageQ <= '0;
    else if (stb.latch) pageQ <= {pageSel, zPtr[Z_W-1:WORD_W+1]};
  end

  assign flashPage = pageQ;
  assign nrwwHit   = (pageQ >= BOUNDARY);
  assign bufRdData = bufMem[bufRdAddr];

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latch |=> $stable(flashPage));
  // R4
  fill_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.fill |=> (bufMem[$past(wordIdx)] == $past(storeData)));

endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fsp_pkg::*;
#(
  parameter int unsigned NRWW_START = 240,
  parameter int          WINDOW     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctlWrEn,
  input  logic [4:0]  ctlWrData,
  output logic [4:0]  ctlBits,
  input  logic        storeStb,
  input  logic [15:0] storeData,
  input  logic [15:0] zPtr,
  input  logic [7:0]  pageSel,
  output logic        busy,
  output logic        cpuHalt,
  output logic        flashReq,
  output logic        flashOp,
  output logic [15:0] flashPage,
  input  logic        flashAck,
  output logic        lockStb,
  output logic [7:0]  lockBits,
  output logic        rwwStb,
  input  logic [6:0]  bufRdAddr,
  output logic [15:0] bufRdData
);

  dpStb_t stb;
  logic   nrwwHit;

  fsp_ctrl #(.WINDOW(WINDOW)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .storeStb(storeStb), .storeLowByte(storeData[7:0]), .flashAck(flashAck),
    .nrwwHit(nrwwHit), .ctlBits(ctlBits), .busy(busy), .cpuHalt(cpuHalt),
    .flashReq(flashReq), .flashOp(flashOp), .lockStb(lockStb),
    .lockBits(lockBits), .rwwStb(rwwStb), .stb(stb)
  );

  fsp_datapath #(
    .WORD_W(7), .DATA_W(16), .Z_W(16), .SEL_W(8), .NRWW_START(NRWW_START)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .storeData(storeData), .zPtr(zPtr),
    .pageSel(pageSel), .bufRdAddr(bufRdAddr), .flashPage(flashPage),
    .nrwwHit(nrwwHit), .bufRdData(bufRdData)
  );

endmodule

// File: tb/flash_selfprog_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_tb_top;

  logic clk = 0;
  logic rstN = 0;
  logic ctlWrEn = 0;
  logic [4:0] ctlWrData = 0;
  logic [4:0] ctlBits;
  logic storeStb = 0;
  logic [15:0] storeData = 0, zPtr = 0;
  logic [7:0] pageSel = 0;
  logic busy, cpuHalt, flashReq, flashOp, lockStb, rwwStb;
  logic [15:0] flashPage, bufRdData;
  logic flashAck = 0;
  logic [7:0] lockBits;
  logic [6:0] bufRdAddr = 0;

  always #4 clk = ~clk;

  flash_selfprog_ctrl dut_i (.*);

  int checks = 0, fails = 0, reqCount = 0, lat = 3;
  bit autoAck = 1, done = 0;
  logic [15:0] expBuf [128];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expPage(input logic [7:0] s, input logic [15:0] z);
    return {s, z[15:8]};
  endfunction

  function automatic logic expHalt(input logic [15:0] p);
    return p >= 16'h00F0;
  endfunction

  task automatic ctlWrite(input logic [4:0] v);
    ctlWrEn = 1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 0;
  endtask

  task automatic store(input logic [15:0] d, input logic [15:0] z, input logic [7:0] s);
    storeStb = 1; storeData = d; zPtr = z; pageSel = s;
    @(negedge clk);
    storeStb = 0;
  endtask

  task automatic readBuf(input int w, output logic [15:0] d);
    bufRdAddr = 7'(w);
    #1 d = bufRdData;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  task automatic sweepBuf(input string req);
    int bad = 0;
    logic [15:0] d;
    for (int i = 0; i < 128; i++) begin
      readBuf(i, d);
      if (d !== expBuf[i]) bad++;
    end
    check(req, bad, 0);
  endtask

  always @(negedge clk) if (flashReq === 1'b1) reqCount++;

  initial forever begin
    @(negedge clk);
    if (flashReq === 1'b1 && autoAck) begin
      repeat (lat - 1) @(negedge clk);
      flashAck = 1;
      @(negedge clk);
      flashAck = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, z;
    int w, dly, rb;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 128; i++) expBuf[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctl", ctlBits, 0);
    check("R1 busy", {busy, cpuHalt, flashReq, lockStb, rwwStb}, 0);
    sweepBuf("R1 buffer");

    // R2 invalid patterns have no effect
    ctlWrite(5'b00111);
    check("R2 invalid idle", ctlBits, 0);
    ctlWrite(5'b00011);
    check("R2 valid", ctlBits, 5'b00011);
    ctlWrite(5'b11111);
    check("R2 invalid armed", ctlBits, 5'b00011);
    repeat (4) @(negedge clk);
    check("R3 erase expired", ctlBits, 0);

    // R3 expiry timing
    ctlWrite(5'b00001);
    repeat (3) @(negedge clk);
    check("R3 still armed", ctlBits, 5'b00001);
    @(negedge clk);
    check("R3 expired", ctlBits, 0);

    // R3 strobe on last window edge accepted
    ctlWrite(5'b00001);
    repeat (3) @(negedge clk);
    store(16'h1234, 16'h0014, 8'h00);
    expBuf[10] = 16'h1234;
    readBuf(10, d);
    check("R3 last edge", d, 16'h1234);
    check("R4 ctl cleared", ctlBits, 0);

    // R10 strobe one edge late ignored
    ctlWrite(5'b00001);
    repeat (4) @(negedge clk);
    store(16'hBEEF, 16'h0014, 8'h00);
    readBuf(10, d);
    check("R10 late strobe", d, 16'h1234);

    // R4 LSB ignored
    ctlWrite(5'b00001);
    store(16'hC0DE, 16'h000B, 8'h00);
    expBuf[5] = 16'hC0DE;
    readBuf(5, d);
    check("R4 lsb ignored", d, 16'hC0DE);

    // R3 R4 random fill with random gap
    for (int it = 0; it < 150; it++) begin
      w = $urandom % 128;
      d = 16'($urandom);
      z = {8'($urandom), 7'(w), 1'($urandom)};
      dly = $urandom % 6;
      ctlWrite(5'b00001);
      repeat (dly) @(negedge clk);
      store(d, z, 8'($urandom));
      if (dly <= 3) expBuf[w] = d;
      repeat (4) @(negedge clk);
      readBuf(w, d);
      check("R4 random fill", d, expBuf[w]);
    end
    check("R3 ctl idle", ctlBits, 0);

    // R5 R6 R10 erase with long latency, low page
    lat = 10;
    rb = reqCount;
    ctlWrite(5'b00011);
    store(16'h0, 16'h1200, 8'h00);
    check("R5 erase busy", {busy, flashReq, flashOp}, 3'b110);
    check("R5 erase page", flashPage, expPage(8'h00, 16'h1200));
    check("R7 erase no halt", cpuHalt, 0);
    zPtr = 16'hFFFF; pageSel = 8'hFF;
    @(negedge clk);
    check("R6 page latched", flashPage, 16'h0012);
    check("R5 single req", flashReq, 0);
    store(16'hDEAD, 16'h000A, 8'h00);
    readBuf(5, d);
    check("R10 strobe busy", d, expBuf[5]);
    ctlWrite(5'b00001);
    check("R10 ctl write busy", ctlBits, 5'b00011);
    check("R5 still busy", busy, 1);
    waitIdle();
    check("R5 erase done ctl", ctlBits, 0);
    check("R5 one request", reqCount - rb, 1);
    sweepBuf("R8 erase keeps buffer");

    // R7 R8 page write to protected page via page select
    lat = 4;
    ctlWrite(5'b00101);
    store(16'h0, 16'h0000, 8'h01);
    check("R7 halt on", cpuHalt, expHalt(16'h0100));
    check("R5 write op", flashOp, 1);
    check("R5 write page", flashPage, 16'h0100);
    @(negedge clk);
    check("R7 halt held", cpuHalt, 1);
    waitIdle();
    check("R7 halt off", cpuHalt, 0);
    for (int i = 0; i < 128; i++) expBuf[i] = 16'hFFFF;
    sweepBuf("R8 write clears");

    // R7 page write just below boundary, and at boundary
    ctlWrite(5'b00001);
    store(16'h7777, 16'hEF06, 8'h00);
    expBuf[3] = 16'h7777;
    ctlWrite(5'b00101);
    store(16'h0, 16'hEF00, 8'h00);
    check("R7 below boundary", {busy, cpuHalt}, 2'b10);
    waitIdle();
    expBuf[3] = 16'hFFFF;
    sweepBuf("R8 write clears 2");
    ctlWrite(5'b00101);
    store(16'h0, 16'hF000, 8'h00);
    check("R7 at boundary", {busy, cpuHalt}, 2'b11);
    waitIdle();

    // R9 lock and re-enable
    rb = reqCount;
    ctlWrite(5'b01001);
    store(16'hA5C3, 16'($urandom), 8'($urandom));
    check("R9 lock pulse", {lockStb, lockBits}, 9'h1C3);
    check("R9 lock ctl", ctlBits, 0);
    @(negedge clk);
    check("R9 lock one cycle", lockStb, 0);
    ctlWrite(5'b10001);
    store(16'h0, 16'h0, 8'h0);
    check("R9 rww pulse", rwwStb, 1);
    @(negedge clk);
    check("R9 rww one cycle", rwwStb, 0);
    check("R9 no request", reqCount - rb, 0);

    // R10 ack while idle
    autoAck = 0;
    ctlWrite(5'b00001);
    flashAck = 1;
    @(negedge clk);
    flashAck = 0;
    check("R10 idle ack", {busy, ctlBits}, 6'b000001);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule